// File: doc/BRIEF.md
# Serial-to-Parallel Output Driver Logic

This block is the digital core of a multi-channel serial-in, parallel-out driver. Such drivers sit in front of high-voltage display or print-head output stages. Serial data arrives with its own shift clock. A shift register advances one stage on every falling edge of that clock. A bank of level-sensitive latches copies the register while the latch enable is high and freezes it while the enable is low. An output stage then applies blanking and polarity to every channel before the channels leave the block.

A cascade output always shows the last stage of the shift register, so several devices can be chained on one serial line. A build-time parameter chooses which end of the register the serial input enters. The chosen end decides how the serial order maps onto the output channels.

The shift clock is an asynchronous input. The block samples it on the system clock through a synchronizer, and each detected falling edge produces one shift. This keeps the whole block on one clock domain.

Top module: `sipo_drive_top`

## Requirements
- R1: The register, the latch bank and the parallel output are each WIDTH bits wide (default 32). A WIDTH-bit word can be loaded and presented in full.
- R2: The shift register advances exactly one stage for each falling edge of `sclk`. The shift takes effect SYNC_STAGES+1 system clocks after the edge. A rising edge, or `sclk` held steady while `sdin` changes, leaves the register unchanged.
- R3: While `le` is high, the latched value follows the shift register, including a shift that occurs while `le` stays high. While `le` is low, the latched value holds, whatever shifting happens.
- R4: `sdout` always shows the last stage of the shift register. The bit sampled at falling edge n appears on `sdout` once falling edge n+WIDTH-1 has taken effect, which is the WIDTH-th edge counting its own.
- R5: The values of `le`, `pol` and `blank_n` have no effect on shifting or on `sdout`.
- R6: While `blank_n` is low, every bit of `hv_out` is 0 (channel off), whatever the latch contents and `pol`.
- R7: While `blank_n` is high, `hv_out[i]` equals latch bit i when `pol` is 1, and the inverse of latch bit i when `pol` is 0.
- R8: With DIR = SHIFT_UP, serial data enters stage 0 and `sdout` is stage WIDTH-1. A word sent most significant bit first then appears on `hv_out` unchanged. With DIR = SHIFT_DOWN, data enters stage WIDTH-1 and `sdout` is stage 0. The same word then appears bit-reversed.
- R9: While `rst_n` is low, and after it is released, the shift register and the latches are cleared. `sdout` is then 0, and `hv_out` is 0 with `pol` at 1 and `blank_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial shift clock; falling edge shifts |
| sdin | input | 1 | Serial data input |
| le | input | 1 | Latch enable: high is transparent, low holds |
| pol | input | 1 | Polarity: 1 passes the latch bits, 0 inverts them |
| blank_n | input | 1 | Active-low blanking; low forces all channels off |
| sdout | output | 1 | Cascade output, the last shift stage |
| hv_out | output | WIDTH | Parallel channel outputs, 1 = on |

## Verification
The hardest case to reach from the ports is a shift that happens while the latches are open. It is the only moment when the parallel output changes without any toggle of `le`. To reach it, the stimulus first loads a full word, holds `le` high, and sends one more falling edge. It then checks that every channel moves by one position, in opposite directions on the two build variants. The stimulus also holds `sclk` low for a long stretch while `sdin` wiggles, and it sends whole words while blanked and with inverted polarity. A scoreboard queue that predicts `sdout` WIDTH edges later catches any shift that was lost or added.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    typedef enum logic {
        SHIFT_UP   = 1'b0,
        SHIFT_DOWN = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic pol;
        logic blank_n;
    } out_ctl_t;

endpackage

// File: rtl/sipo_edge_sync.sv
module sipo_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdin,
    output logic shift_fire,
    output logic shift_bit
);
    localparam int S = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [S-1:0] clk_pipe;
        logic [S-1:0] dat_pipe;
        logic         clk_prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.clk_pipe = {st_q.clk_pipe[S-2:0], sclk};
        st_d.dat_pipe = {st_q.dat_pipe[S-2:0], sdin};
        st_d.clk_prev = st_q.clk_pipe[S-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shift_fire = st_q.clk_prev & ~st_q.clk_pipe[S-1];
    assign shift_bit  = st_q.dat_pipe[S-1];

endmodule

// File: rtl/sipo_shift_reg.sv
module sipo_shift_reg
    import sipo_pkg::*;
#(
    parameter int         WIDTH = 32,
    parameter shift_dir_e DIR   = SHIFT_UP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             din,
    output logic [WIDTH-1:0] stages,
    output logic             tail
);
    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } shreg_t;

    shreg_t           st_d, st_q;
    logic [WIDTH-1:0] moved;

    generate
        if (DIR == SHIFT_UP) begin : g_up
            assign moved = {st_q.sr[LAST-1:0], din};
            assign tail  = st_q.sr[LAST];
        end else begin : g_down
            assign moved = {din, st_q.sr[LAST:1]};
            assign tail  = st_q.sr[0];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (fire) st_d.sr = moved;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stages = st_q.sr;

endmodule

// File: rtl/sipo_latch_bank.sv
module sipo_latch_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] view,
    output logic [WIDTH-1:0] held
);
    typedef struct packed {
        logic [WIDTH-1:0] lat;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (le) st_d.lat = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held = st_q.lat;
    assign view = le ? din : st_q.lat;

endmodule

// File: rtl/sipo_out_stage.sv
module sipo_out_stage
    import sipo_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  out_ctl_t         ctl,
    input  logic [WIDTH-1:0] bits,
    output logic [WIDTH-1:0] drive
);
    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_ch
        always_comb begin
            if (!ctl.blank_n) drive[ch] = 1'b0;
            else              drive[ch] = ctl.pol ? bits[ch] : ~bits[ch];
        end
    end

endmodule

// File: rtl/sipo_drive_top.sv
module sipo_drive_top
    import sipo_pkg::*;
#(
    parameter int         WIDTH       = 32,
    parameter int         SYNC_STAGES = 2,
    parameter shift_dir_e DIR         = SHIFT_UP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             sdin,
    input  logic             le,
    input  logic             pol,
    input  logic             blank_n,
    output logic             sdout,
    output logic [WIDTH-1:0] hv_out
);
    logic             shift_fire;
    logic             shift_bit;
    logic [WIDTH-1:0] shift_stages;
    logic [WIDTH-1:0] latch_view;
    logic [WIDTH-1:0] latch_held;
    out_ctl_t         ctl;

    assign ctl.pol     = pol;
    assign ctl.blank_n = blank_n;

    sipo_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .sdin       (sdin),
        .shift_fire (shift_fire),
        .shift_bit  (shift_bit)
    );

    sipo_shift_reg #(.WIDTH(WIDTH), .DIR(DIR)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (shift_fire),
        .din    (shift_bit),
        .stages (shift_stages),
        .tail   (sdout)
    );

    sipo_latch_bank #(.WIDTH(WIDTH)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le),
        .din   (shift_stages),
        .view  (latch_view),
        .held  (latch_held)
    );

    sipo_out_stage #(.WIDTH(WIDTH)) u_out (
        .ctl   (ctl),
        .bits  (latch_view),
        .drive (hv_out)
    );

endmodule

// File: rtl/sipo_drive_chk.sv
module sipo_drive_chk
    import sipo_pkg::*;
#(
    parameter int         WIDTH = 32,
    parameter shift_dir_e DIR   = SHIFT_UP
) (
    input logic             clk,
    input logic             rst_n,
    input logic             le,
    input logic             pol,
    input logic             blank_n,
    input logic             shift_fire,
    input logic [WIDTH-1:0] shift_stages,
    input logic [WIDTH-1:0] latch_held,
    input logic             sdout,
    input logic [WIDTH-1:0] hv_out
);
    localparam int PRE = (DIR == SHIFT_UP) ? WIDTH - 2 : 1;

    // R2: no detected edge, no movement
    p_no_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_fire |=> $stable(shift_stages));

    // R4: after a shift the cascade pin shows the stage that was next to last
    p_cascade_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_fire |=> sdout == $past(shift_stages[PRE]));

    // R3: open latches copy the register
    p_latch_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> latch_held == $past(shift_stages));

    // R3: closed latches keep their value
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> $stable(latch_held));

    // R6: blanking turns every channel off
    p_blank_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> hv_out == '0);

    // R7: flipping polarity with closed latches inverts every channel
    p_pol_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && $past(blank_n) && !le && $past(!le) && pol != $past(pol))
        |-> hv_out == ~$past(hv_out));

endmodule

bind sipo_drive_top sipo_drive_chk #(.WIDTH(WIDTH), .DIR(DIR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .le           (le),
    .pol          (pol),
    .blank_n      (blank_n),
    .shift_fire   (shift_fire),
    .shift_stages (shift_stages),
    .latch_held   (latch_held),
    .sdout        (sdout),
    .hv_out       (hv_out)
);

// File: tb/tb_sipo_drive_top.sv
module tb_sipo_drive_top;
    import sipo_pkg::*;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b1;
    logic         sdin = 1'b0;
    logic         le = 1'b0;
    logic         pol = 1'b1;
    logic         blank_n = 1'b1;
    logic         sdout_f, sdout_r;
    logic [W-1:0] hv_f, hv_r;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic q_exp[$];
    event bit_done;

    always #10 clk = ~clk;

    sipo_drive_top #(.WIDTH(W), .DIR(SHIFT_UP)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .le(le),
        .pol(pol), .blank_n(blank_n), .sdout(sdout_f), .hv_out(hv_f));

    sipo_drive_top #(.WIDTH(W), .DIR(SHIFT_DOWN)) dut_rev (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .le(le),
        .pol(pol), .blank_n(blank_n), .sdout(sdout_r), .hv_out(hv_r));

    function automatic logic [W-1:0] rev(input logic [W-1:0] v);
        for (int i = 0; i < W; i++) rev[i] = v[W-1-i];
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: one falling edge per bit, expected cascade bit queued
    task automatic send_bit(input logic b);
        @(negedge clk);
        sdin = b;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        q_exp.push_back(b);
        repeat (4) @(negedge clk);
        -> bit_done;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    // monitor: bit queued WIDTH edges ago must now be on both cascade pins
    initial begin
        forever begin
            @(bit_done);
            if (q_exp.size() >= W) begin
                logic e;
                e = q_exp.pop_front();
                check("R4 R5 cascade fwd", {{(W-1){1'b0}}, sdout_f}, {{(W-1){1'b0}}, e});
                check("R4 R5 cascade rev", {{(W-1){1'b0}}, sdout_r}, {{(W-1){1'b0}}, e});
            end
        end
    end

    task automatic expect_out(input string req, input logic [W-1:0] ef, input logic [W-1:0] er);
        @(negedge clk);
        check({req, " fwd"}, hv_f, ef);
        check({req, " rev"}, hv_r, er);
    endtask

    initial begin
        logic [W-1:0] w1, w2, sh_f, sh_r;
        w1 = 32'hA5C3_0F81;
        w2 = 32'h1357_9BDF;

        repeat (3) @(negedge clk);
        expect_out("R9 in reset", '0, '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_out("R9 after reset", '0, '0);
        check("R9 sdout", {{(W-1){1'b0}}, sdout_f | sdout_r}, '0);

        // R8 R1: load a word, latches closed -> outputs hold
        send_word(w1);
        expect_out("R3 hold while loading", '0, '0);
        le = 1'b1;
        expect_out("R8 R1 transparent load", w1, rev(w1));
        le = 1'b0;
        repeat (2) @(negedge clk);
        expect_out("R3 hold after close", w1, rev(w1));

        // R7 polarity, R6 blanking
        pol = 1'b0;
        expect_out("R7 inverted", ~w1, ~rev(w1));
        blank_n = 1'b0;
        expect_out("R6 blank inv", '0, '0);
        pol = 1'b1;
        expect_out("R6 blank pass", '0, '0);

        // R5: shifting while blanked and inverted still feeds cascade
        pol = 1'b0;
        send_word(w2);
        pol = 1'b1;
        blank_n = 1'b1;
        expect_out("R3 latch held over shift", w1, rev(w1));
        le = 1'b1;
        expect_out("R5 R8 second word", w2, rev(w2));

        // R3 R2: shift while transparent moves outputs one place
        send_bit(1'b1);
        sh_f = {w2[W-2:0], 1'b1};
        sh_r = {1'b1, rev(w2) >> 1} ;
        sh_r[W-1] = 1'b1;
        expect_out("R3 R2 shift while open", sh_f, sh_r);

        // R2: no falling edge -> no shift despite sdin activity and rising edge
        @(negedge clk);
        sclk = 1'b0;
        for (int i = 0; i < 20; i++) begin
            sdin = ~sdin;
            @(negedge clk);
        end
        sclk = 1'b1;
        repeat (6) @(negedge clk);
        expect_out("R2 no edge no shift", sh_f, sh_r);
        le = 1'b0;

        // more cascade traffic
        send_word(32'hFFFF_0000);
        send_word(32'h0000_0001);
        le = 1'b1;
        expect_out("R8 R1 third word", 32'h0000_0001, rev(32'h0000_0001));
        le = 1'b0;

        // R9: reset mid-run clears everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        expect_out("R9 reset clears latches", '0, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 reset clears cascade", {{(W-1){1'b0}}, sdout_f | sdout_r}, '0);
        le = 1'b1;
        expect_out("R9 reset clears register", '0, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule